// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Select

This block keeps a 16-bit accumulator that counts either edges of an external pin or timer-derived ticks gated by the pin's level. Two control bits set the mode. In event mode the count goes up by one on each chosen edge of the pin. In gated mode the count goes up on each divide-by-64 tick from the timer prescaler while the pin is at the chosen level. Because that tick comes from the prescaler, gated counting stops when the timer is disabled. The pin passes through a two-flop synchroniser before any edge is detected.

The same accumulator clock can drive the main timer counter in place of the prescaler clock. It can be used directly, divided by 256 (the carry out of the low byte of the count), or divided by 65536 (the 16-bit wrap). This choice has effect only while the accumulator is enabled. An overflow flag and an input flag record wraps and pin events. Software clears them by writing ones, or, in fast-clear mode, by any access to the count. A plain single-cycle register port reads and writes the count and the flags. All clocks are modelled as single-cycle enables in one clock domain.

Top module: `pulse_acc_clksel`

## Requirements
- R1: After reset the count reads 0x0000 and the flag register reads 0x0000.
- R2: With `modeSel`=00 the count rises by one per falling pin edge, and with `modeSel`=01 by one per rising pin edge. The other edge has no effect. The new count is readable after the third rising clock edge following the pin change.
- R3: With `modeSel`=10 (pin high) or 11 (pin low), each `div64Tick` pulse while the pin is at that level adds one to the count. No tick counts while the pin is at the other level or while `timerEn` is 0.
- R4: The count changes only while `accEn` is 1, except that a write with `regAddr`=0 loads `regWdata` into it.
- R5: With `accEn`=1, `cntTick` follows the value of `clkSel`: 00 gives `prescTick`, 01 gives the accumulator clock, 10 gives the accumulator clock on a low-byte carry (count[7:0]=0xFF), and 11 gives the accumulator clock on the 16-bit wrap (count=0xFFFF). The new select takes effect in the same cycle.
- R6: With `accEn`=0, `cntTick` equals `prescTick` whatever `clkSel` holds.
- R7: A wrap from 0xFFFF to 0x0000 sets the overflow flag.
- R8: The input flag sets on each counted edge in event mode and on the gate's trailing edge in gated mode (falling for 10, rising for 11), only while `accEn` is 1.
- R9: The flag register (`regAddr`=1) holds the overflow flag at bit 1 and the input flag at bit 0. Bits 15 to 2 read as 0.
- R10: With `fastClr`=0, writing 1 to a flag bit clears that flag and writing 0 leaves it. If a set and a clear fall in the same cycle, the set wins.
- R11: With `fastClr`=1, any read or write with `regAddr`=0 clears both flags, and writes to the flag register have no effect.
- R12: When `timerEn` and `accEn` are both 0, no flag can be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerEn | input | 1 | Timer enable; gates the divide-by-64 tick |
| accEn | input | 1 | Accumulator enable |
| modeSel | input | 2 | 00 fall, 01 rise, 10 gate high, 11 gate low |
| clkSel | input | 2 | Timer counter clock select |
| fastClr | input | 1 | Clear flags on any count access |
| prescTick | input | 1 | Prescaler clock enable pulse |
| div64Tick | input | 1 | Prescaler divide-by-64 pulse |
| pinIn | input | 1 | Asynchronous external pin |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 count, 1 flags |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data (combinational) |
| cntTick | output | 1 | Timer counter clock enable |

## Verification
The hardest case to reach is a flag set and a flag clear landing in the same cycle. To get there, the bench first loads the count with 0xFFFF. It then raises `div64Tick` with the gate open in the same cycle as a write-one to the overflow bit, so the wrap and the clear meet at one clock edge. The divided clock outputs are also hard to reach by counting alone, because they need up to 65536 ticks. The vector table therefore preloads the count to just below each carry boundary and then applies a single accumulator tick.

// File: rtl/pa_pkg.sv
package pa_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accClk;   // accumulator clock enable
    logic loadCnt;  // software load of the count
    logic setEdge;  // input-flag set event
    logic clrOvf;   // overflow flag clear
    logic clrEdge;  // input flag clear
  } paStrobe_t;
endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       timerEn,
  input  logic       accEn,
  input  logic [1:0] modeSel,
  input  logic       fastClr,
  input  logic       div64Tick,
  input  logic       pinIn,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       regAddr,
  input  logic [1:0] flagWdata,
  output paStrobe_t  strb
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] syncQ;
  logic         pinPrev;
  logic         pinLvl;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[MSB-1:0], pinIn};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end
  endgenerate

  assign pinLvl = syncQ[MSB];

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinLvl;
  end

  logic riseEv, fallEv, activeEdge, gateOn, gatedMode;
  logic clrAllowed, fastHit, wrFlags;

  always_comb begin
    riseEv     = pinLvl & ~pinPrev;
    fallEv     = ~pinLvl & pinPrev;
    // event edge and gate trailing edge share the same polarity bit
    activeEdge = modeSel[0] ? riseEv : fallEv;
    gatedMode  = modeSel[1];
    gateOn     = modeSel[0] ? ~pinLvl : pinLvl;

    strb.accClk  = accEn & (gatedMode ? (div64Tick & timerEn & gateOn) : activeEdge);
    strb.loadCnt = regWr & ~regAddr;
    strb.setEdge = accEn & activeEdge;

    clrAllowed   = timerEn | accEn;
    fastHit      = fastClr & (regWr | regRd) & ~regAddr;
    wrFlags      = ~fastClr & regWr & regAddr;
    strb.clrOvf  = clrAllowed & (fastHit | (wrFlags & flagWdata[1]));
    strb.clrEdge = clrAllowed & (fastHit | (wrFlags & flagWdata[0]));
  end
endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import pa_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LO_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  paStrobe_t        strb,
  input  logic             accEn,
  input  logic             prescTick,
  input  logic [1:0]       clkSel,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             edgeFlag,
  output logic             cntTick
);
  logic adv, carryLo, wrap;

  always_comb begin
    adv     = strb.accClk & ~strb.loadCnt;
    carryLo = adv & (&count[LO_W-1:0]);
    wrap    = adv & (&count);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             count <= '0;
    else if (strb.loadCnt) count <= regWdata;
    else if (adv)          count <= count + 1'b1;
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      edgeFlag <= 1'b0;
    end else begin
      if (wrap)              ovfFlag  <= 1'b1;
      else if (strb.clrOvf)  ovfFlag  <= 1'b0;
      if (strb.setEdge)      edgeFlag <= 1'b1;
      else if (strb.clrEdge) edgeFlag <= 1'b0;
    end
  end

  always_comb begin
    cntTick = prescTick;
    if (accEn) begin
      unique case (clkSel)
        2'b00: cntTick = prescTick;
        2'b01: cntTick = adv;
        2'b10: cntTick = carryLo;
        2'b11: cntTick = wrap;
      endcase
    end
  end
endmodule

// File: rtl/pulse_acc_clksel.sv
module pulse_acc_clksel
  import pa_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timerEn,
  input  logic             accEn,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       clkSel,
  input  logic             fastClr,
  input  logic             prescTick,
  input  logic             div64Tick,
  input  logic             pinIn,
  input  logic             regWr,
  input  logic             regRd,
  input  logic             regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  output logic             cntTick
);
  paStrobe_t        strb;
  logic [CNT_W-1:0] cntQ;
  logic             ovfQ, edgeQ;

  pa_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .accEn(accEn),
    .modeSel(modeSel), .fastClr(fastClr), .div64Tick(div64Tick),
    .pinIn(pinIn), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .flagWdata(regWdata[1:0]), .strb(strb)
  );

  pa_datapath #(.CNT_W(CNT_W), .LO_W(LO_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .accEn(accEn),
    .prescTick(prescTick), .clkSel(clkSel), .regWdata(regWdata),
    .count(cntQ), .ovfFlag(ovfQ), .edgeFlag(edgeQ), .cntTick(cntTick)
  );

  assign regRdata = regAddr ? {{(CNT_W-2){1'b0}}, ovfQ, edgeQ} : cntQ;
endmodule

// File: rtl/pa_clksel_chk.sv
module pa_clksel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             timerEn,
  input logic             accEn,
  input logic             prescTick,
  input logic             regWr,
  input logic             regAddr,
  input logic [CNT_W-1:0] regRdata,
  input logic             cntTick,
  input logic [CNT_W-1:0] cnt,
  input logic             ovfFlag,
  input logic             edgeFlag
);
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accEn && !(regWr && !regAddr)) |=> $stable(cnt));

  // R7
  wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(cnt) == {CNT_W{1'b1}}));

  // R12
  no_clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !accEn) |=> (!$fell(ovfFlag) && !$fell(edgeFlag)));

  // R9
  flag_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> (regRdata[CNT_W-1:2] == '0));

  // R6
  presc_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |-> (cntTick == prescTick));

  // R8
  edge_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(edgeFlag) |-> $past(accEn));
endmodule

bind pulse_acc_clksel pa_clksel_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .timerEn(timerEn), .accEn(accEn),
  .prescTick(prescTick), .regWr(regWr), .regAddr(regAddr),
  .regRdata(regRdata), .cntTick(cntTick), .cnt(cntQ),
  .ovfFlag(ovfQ), .edgeFlag(edgeQ)
);

// File: tb/tb_pulse_acc_clksel.sv
module tb_pulse_acc_clksel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timerEn = 1'b0, accEn = 1'b0, fastClr = 1'b0;
  logic [1:0]  modeSel = 2'b00, clkSel = 2'b00;
  logic        prescTick = 1'b0, div64Tick = 1'b0, pinIn = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0, regAddr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        cntTick;

  int nVec = 0;
  int nBad = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  pulse_acc_clksel dut (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .accEn(accEn),
    .modeSel(modeSel), .clkSel(clkSel), .fastClr(fastClr),
    .prescTick(prescTick), .div64Tick(div64Tick), .pinIn(pinIn),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cntTick(cntTick)
  );

  typedef struct packed {
    logic        en;
    logic [1:0]  sel;
    logic        presc;
    logic [15:0] preset;
    logic        exp;
  } vec_t;

  // R5 R6 R7: clock select with one accumulator tick at a chosen count
  localparam vec_t VECS [11] = '{
    '{1'b1, 2'd0, 1'b1, 16'h0000, 1'b1},
    '{1'b1, 2'd0, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 2'd1, 1'b0, 16'h0005, 1'b1},
    '{1'b1, 2'd2, 1'b0, 16'h00FF, 1'b1},
    '{1'b1, 2'd2, 1'b0, 16'h0100, 1'b0},
    '{1'b1, 2'd2, 1'b0, 16'h12FF, 1'b1},
    '{1'b1, 2'd3, 1'b0, 16'hFFFF, 1'b1},
    '{1'b1, 2'd3, 1'b0, 16'h00FF, 1'b0},
    '{1'b0, 2'd1, 1'b0, 16'hFFFF, 1'b0},
    '{1'b0, 2'd3, 1'b1, 16'h0000, 1'b1},
    '{1'b0, 2'd2, 1'b0, 16'h00FF, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [15:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic pinSet(input logic v);
    pinIn = v;
    tick(4);
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      div64Tick = 1'b1;
      @(negedge clk);
      div64Tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    readReg(1'b0, rv); chk("R1 count", rv, 16'h0000);
    readReg(1'b1, rv); chk("R1 flags", rv, 16'h0000);

    // event mode, falling edges
    timerEn = 1'b1; accEn = 1'b1; modeSel = 2'b00;
    pinSet(1'b1);
    readReg(1'b0, rv); chk("R2 rise ignored in 00", rv, 16'h0000);
    pinIn = 1'b0;
    tick(2);
    readReg(1'b0, rv); chk("R2 not before third edge", rv, 16'h0000);
    tick(1);
    readReg(1'b0, rv); chk("R2 fall counted", rv, 16'h0001);
    tick(1);
    readReg(1'b1, rv); chk("R8 R9 input flag bit0", rv, 16'h0001);
    writeReg(1'b1, 16'hFFFE);
    readReg(1'b1, rv); chk("R10 write zero keeps", rv, 16'h0001);
    writeReg(1'b1, 16'h0001);
    readReg(1'b1, rv); chk("R10 write one clears", rv, 16'h0000);

    // rising edges
    modeSel = 2'b01;
    pinSet(1'b1);
    readReg(1'b0, rv); chk("R2 rise counted in 01", rv, 16'h0002);
    pinSet(1'b0);
    readReg(1'b0, rv); chk("R2 fall ignored in 01", rv, 16'h0002);
    writeReg(1'b1, 16'h0001);

    // disabled accumulator
    accEn = 1'b0; modeSel = 2'b00;
    pinSet(1'b1); pinSet(1'b0);
    readReg(1'b0, rv); chk("R4 no count while disabled", rv, 16'h0002);
    readReg(1'b1, rv); chk("R8 no flag while disabled", rv, 16'h0000);
    accEn = 1'b1;
    writeReg(1'b0, 16'h1234);
    readReg(1'b0, rv); chk("R4 load", rv, 16'h1234);

    // gated accumulation
    modeSel = 2'b10;
    pinSet(1'b1);
    pulses(3);
    readReg(1'b0, rv); chk("R3 gate high counts", rv, 16'h1237);
    timerEn = 1'b0;
    pulses(2);
    readReg(1'b0, rv); chk("R3 timer off stops", rv, 16'h1237);
    timerEn = 1'b1;
    pinSet(1'b0);
    readReg(1'b1, rv); chk("R8 trailing gate edge", rv, 16'h0001);
    pulses(2);
    readReg(1'b0, rv); chk("R3 gate closed", rv, 16'h1237);
    modeSel = 2'b11;
    pulses(2);
    readReg(1'b0, rv); chk("R3 gate low counts", rv, 16'h1239);
    writeReg(1'b1, 16'h0001);

    // overflow
    writeReg(1'b0, 16'hFFFF);
    pulses(1);
    readReg(1'b0, rv); chk("R7 wrap to zero", rv, 16'h0000);
    readReg(1'b1, rv); chk("R7 R9 overflow bit1", rv, 16'h0002);

    timerEn = 1'b0; accEn = 1'b0;
    writeReg(1'b1, 16'h0003);
    readReg(1'b1, rv); chk("R12 clear blocked", rv, 16'h0002);
    timerEn = 1'b1; accEn = 1'b1;
    writeReg(1'b1, 16'h0002);
    readReg(1'b1, rv); chk("R10 overflow cleared", rv, 16'h0000);

    // set and clear in one cycle
    writeReg(1'b0, 16'hFFFF);
    div64Tick = 1'b1; regAddr = 1'b1; regWdata = 16'h0002; regWr = 1'b1;
    @(negedge clk);
    div64Tick = 1'b0; regWr = 1'b0;
    readReg(1'b1, rv); chk("R10 set wins", rv, 16'h0002);

    // fast clear
    fastClr = 1'b1;
    pinSet(1'b1);
    readReg(1'b1, rv); chk("R8 gate low trailing", rv, 16'h0003);
    writeReg(1'b1, 16'h0003);
    readReg(1'b1, rv); chk("R11 flag write ignored", rv, 16'h0003);
    regAddr = 1'b0; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    readReg(1'b1, rv); chk("R11 count read clears", rv, 16'h0000);
    fastClr = 1'b0;

    // clock select table
    modeSel = 2'b10;
    pinSet(1'b1);
    foreach (VECS[i]) begin
      writeReg(1'b0, VECS[i].preset);
      accEn = VECS[i].en; clkSel = VECS[i].sel;
      prescTick = VECS[i].presc; div64Tick = 1'b1;
      #1;
      chk($sformatf("R5 R6 vector %0d", i), {15'b0, cntTick}, {15'b0, VECS[i].exp});
      @(negedge clk);
      div64Tick = 1'b0; prescTick = 1'b0; accEn = 1'b1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule